// File: doc/BRIEF.md
# Iterative Radix-2 Montgomery Multiplier

This unit computes the Montgomery product A·B·2^(-n) mod N by the bit-serial radix-2 method. Each iteration looks at one bit of A and does nothing harder than two conditional additions and a one-bit right shift. The operand length n is chosen per operation, up to the build-time width `MAX_W`. The host supplies A, B, an odd modulus N and n, then raises a request. The unit captures everything on that request and runs on its own. It signals `busy_o` while it works and pulses `done_o` once the result on `res_o` is valid.

There are two ways to run an operation.

- **Atomic mode** runs every iteration and the final correction in a single request.
- **Partial mode** runs one iteration per request. The accumulator and the bit counter stay inside the unit between requests, so the host can serve other work between steps. The last step also applies the final conditional subtraction and presents the result.

Top module: `mont_mul_r2`

## Requirements
- R1: On completion `res_o` equals A·B·2^(-n) mod N, and it is below N. This holds for odd N < 2^n, A < N, B < N and 1 ≤ n ≤ `MAX_W`.
- R2: In atomic mode (`mode_i`=0), a `start_i` sampled while idle makes `busy_o` stay high for exactly 2·n+1 cycles, starting in the cycle after the accepting edge. `done_o` rises in the cycle where `busy_o` falls.
- R3: In partial mode (`mode_i`=1), each accepted request keeps `busy_o` high for 2 cycles. The request carrying iteration n also keeps it high for one extra cycle, for 3 in total. `done_o` pulses only after that final request.
- R4: A, B, N and n are captured at the accepting edge. Changes on `a_i`, `b_i`, `n_i` or `len_i` after that edge have no effect on the result.
- R5: `start_i` and `step_i` are ignored while `busy_o` is high.
- R6: `done_o` is high for a single cycle and never together with `busy_o`. `res_o` keeps its value until the next completion.
- R7: A `step_i` while no partial operation is loaded captures the operands and starts a partial operation, as if `start_i` had been given with `mode_i`=1.
- R8: A `start_i` while a partial operation is paused discards that operation's state. The new operation starts from scratch with the new operands.
- R9: After reset `busy_o`=0, `done_o`=0 and `res_o`=0.
- R10: The lengths n=1 and n=`MAX_W` give correct results and timing in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and begin; has priority over step_i |
| step_i | input | 1 | Partial mode: run the next iteration |
| mode_i | input | 1 | 0 = atomic, 1 = partial; sampled with start_i |
| len_i | input | $clog2(MAX_W+1) | Operand length n in bits |
| a_i | input | MAX_W | Multiplicand A |
| b_i | input | MAX_W | Multiplier B |
| n_i | input | MAX_W | Odd modulus N |
| busy_o | output | 1 | Operation or step in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| res_o | output | MAX_W | Montgomery product |

## Verification
The assertions rely on the host keeping to the operand contract. On every accepted request the length lies between 1 and `MAX_W`, N is odd and fits in n bits, and A and B are both below N. Under those conditions the accumulator stays below 2N, so the result-below-modulus property is meaningful. The stimulus builds each modulus by masking a random value to n bits and forcing its top and bottom bits to one. It then reduces random A and B modulo that N, so every request stays inside the contract. Requests issued while busy, and operand changes made during a run, are deliberate and fall within the inputs the unit must ignore.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_SHIFT,
    ST_FIN
  } mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int MAX_W = 64,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             calc_o,
  output logic             shift_o,
  output logic             fin_o,
  output logic             busy_o,
  output logic             done_o
);
  mm_state_e        state_q;
  logic [LEN_W-1:0] len_q, cnt_q, cnt_nx;
  logic             part_q, loaded_q, done_q;
  logic             accept_new, accept_step, mode_new;

  // a step with nothing loaded behaves as a partial-mode start
  assign accept_new  = (state_q == ST_IDLE) && (start_i || (step_i && !loaded_q));
  assign accept_step = (state_q == ST_IDLE) && !start_i && step_i && loaded_q;
  assign mode_new    = start_i ? mode_i : 1'b1;
  assign cnt_nx      = cnt_q + {{(LEN_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      cnt_q    <= '0;
      part_q   <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_new) begin
            len_q    <= len_i;
            part_q   <= mode_new;
            loaded_q <= mode_new;
            cnt_q    <= '0;
            state_q  <= ST_CALC;
          end else if (accept_step) begin
            state_q <= ST_CALC;
          end
        end
        ST_CALC: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          cnt_q <= cnt_nx;
          if (cnt_nx == len_q) state_q <= ST_FIN;
          else if (part_q)     state_q <= ST_IDLE;
          else                 state_q <= ST_CALC;
        end
        ST_FIN: begin
          state_q  <= ST_IDLE;
          loaded_q <= 1'b0;
          done_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o  = accept_new;
  assign calc_o  = (state_q == ST_CALC);
  assign shift_o = (state_q == ST_SHIFT);
  assign fin_o   = (state_q == ST_FIN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/mm_csub.sv
module mm_csub #(
  parameter int W = 64
) (
  input  logic [W+1:0] acc_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] red_o
);
  logic         ge;
  logic [W-1:0] diff;

  assign ge    = acc_i >= {2'b00, mod_i};
  // true difference is below the modulus, so W bits suffice
  assign diff  = acc_i[W-1:0] - mod_i;
  assign red_o = ge ? diff : acc_i[W-1:0];
endmodule

// File: rtl/mm_dp.sv
module mm_dp #(
  parameter int MAX_W = 64,
  localparam int SW = MAX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             calc_i,
  input  logic             shift_i,
  input  logic             fin_i,
  input  logic [MAX_W-1:0] a_i,
  input  logic [MAX_W-1:0] b_i,
  input  logic [MAX_W-1:0] n_i,
  output logic [MAX_W-1:0] res_o,
  output logic [MAX_W-1:0] mod_o
);
  logic [MAX_W-1:0] a_q, b_q, n_q, res_q, red;
  logic [SW-1:0]    acc_q, add_b, add_n, sum;
  logic             a_bit, q_bit;

  assign a_bit = a_q[0];
  assign q_bit = acc_q[0] ^ (a_bit & b_q[0]);
  assign add_b = a_bit ? {2'b00, b_q} : '0;
  assign add_n = q_bit ? {2'b00, n_q} : '0;
  assign sum   = acc_q + add_b + add_n;

  mm_csub #(.W(MAX_W)) u_csub (
    .acc_i (acc_q),
    .mod_i (n_q),
    .red_o (red)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      n_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else if (load_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      n_q   <= n_i;
      acc_q <= '0;
    end else if (calc_i) begin
      acc_q <= sum;
    end else if (shift_i) begin
      acc_q <= acc_q >> 1;
      a_q   <= a_q >> 1;
    end else if (fin_i) begin
      res_q <= red;
    end
  end

  assign res_o = res_q;
  assign mod_o = n_q;
endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2 #(
  parameter int MAX_W = 64,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MAX_W-1:0] a_i,
  input  logic [MAX_W-1:0] b_i,
  input  logic [MAX_W-1:0] n_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [MAX_W-1:0] res_o
);
  logic             load, calc, shift, fin;
  logic [MAX_W-1:0] mod_hold;

  mm_ctrl #(.MAX_W(MAX_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (step_i),
    .mode_i  (mode_i),
    .len_i   (len_i),
    .load_o  (load),
    .calc_o  (calc),
    .shift_o (shift),
    .fin_o   (fin),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mm_dp #(.MAX_W(MAX_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .calc_i  (calc),
    .shift_i (shift),
    .fin_i   (fin),
    .a_i     (a_i),
    .b_i     (b_i),
    .n_i     (n_i),
    .res_o   (res_o),
    .mod_o   (mod_hold)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int MAX_W = 64,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             step_i,
  input logic             mode_i,
  input logic [LEN_W-1:0] len_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [MAX_W-1:0] res_o,
  input logic [MAX_W-1:0] mod_hold
);
  logic [31:0]      cyc_q;
  logic [LEN_W-1:0] len_cap_q;
  logic             atom_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q     <= '0;
      len_cap_q <= '0;
      atom_q    <= 1'b0;
    end else if (!busy_o && start_i) begin
      cyc_q     <= '0;
      len_cap_q <= len_i;
      atom_q    <= !mode_i;
    end else if (!busy_o && step_i) begin
      atom_q <= 1'b0;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 32'd1;
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> (len_i >= 1 && 32'(len_i) <= MAX_W)); // R1
  AST_RES_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_o < mod_hold)); // R1
  AST_ATOMIC_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && atom_q) |-> (cyc_q == 32'(len_cap_q) * 2 + 32'd1)); // R2
  AST_START_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mod_hold)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o)); // R6
endmodule

bind mont_mul_r2 mm_checker #(.MAX_W(MAX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .step_i   (step_i),
  .mode_i   (mode_i),
  .len_i    (len_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .res_o    (res_o),
  .mod_hold (mod_hold)
);

// File: tb/sim_mont_mul_r2.sv
module sim_mont_mul_r2;
  localparam int W  = 64;
  localparam int LW = $clog2(W + 1);

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0, step_i = 1'b0, mode_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [W-1:0]  a_i = '0, b_i = '0, n_i = '0;
  logic          busy_o, done_o;
  logic [W-1:0]  res_o;

  int total = 0, bad = 0, cycles = 0;

  always #2 clk_i = ~clk_i;

  mont_mul_r2 #(.MAX_W(W)) u0 (
    .clk_i, .rst_ni, .start_i, .step_i, .mode_i, .len_i,
    .a_i, .b_i, .n_i, .busy_o, .done_o, .res_o
  );

  // reference: (A*B mod N) * inverse(2)^n mod N, inverse(2) = (N+1)/2
  function automatic logic [W-1:0] mont_ref(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] n, int len);
    logic [127:0] p, h, nn;
    nn = {64'd0, n};
    h  = (nn + 128'd1) >> 1;
    p  = ({64'd0, a} * {64'd0, b}) % nn;
    for (int i = 0; i < len; i++) p = (p * h) % nn;
    return p[W-1:0];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // cycle model
  int           m_rem, m_len, m_iter;
  bit           m_fin, m_loaded, m_part, m_done;
  logic [W-1:0] m_res, m_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rem = 0; m_fin = 0; m_loaded = 0; m_part = 0; m_done = 0;
      m_res = '0; m_pend = '0; m_len = 0; m_iter = 0;
    end else begin
      m_done = 0;
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0 && m_fin) begin
          m_done = 1; m_res = m_pend; m_loaded = 0;
        end
      end else if (start_i || step_i) begin
        if (start_i || !m_loaded) begin
          m_len    = int'(len_i);
          m_part   = start_i ? mode_i : 1'b1;
          m_pend   = mont_ref(a_i, b_i, n_i, m_len);
          m_iter   = 0;
          m_loaded = m_part;
        end
        if (!m_part) begin
          m_rem = 2 * m_len + 1; m_fin = 1;
        end else begin
          m_iter++;
          m_fin = (m_iter == m_len);
          m_rem = m_fin ? 3 : 2;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R2/R3 busy", W'(busy_o), W'(m_rem > 0));
      chk("R6 done", W'(done_o), W'(m_done));
      chk("R1 res", res_o, m_res);
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL R2 watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic make_ops(int len, output logic [W-1:0] a, output logic [W-1:0] b,
                          output logic [W-1:0] n);
    logic [W-1:0] mask;
    mask = (len == W) ? '1 : ((64'd1 << len) - 64'd1);
    n = ({$urandom, $urandom} & mask) | 64'd1;
    if (len > 1) n = n | (64'd1 << (len - 1));
    a = {$urandom, $urandom} % n;
    b = {$urandom, $urandom} % n;
  endtask

  task automatic req(bit st, bit sp, bit md, int len, logic [W-1:0] a,
                     logic [W-1:0] b, logic [W-1:0] n);
    @(negedge clk_i);
    start_i = st; step_i = sp; mode_i = md; len_i = LW'(len);
    a_i = a; b_i = b; n_i = n;
    @(negedge clk_i);
    start_i = 0; step_i = 0;
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (busy_o) begin
      c++;
      @(negedge clk_i);
    end
  endtask

  task automatic run_atomic(int len, string tag);
    logic [W-1:0] a, b, n, held;
    int c;
    make_ops(len, a, b, n);
    req(1, 0, 0, len, a, b, n);
    wait_idle(c);
    chk({tag, " R2 atomic busy cycles"}, W'(c), W'(2 * len + 1));
    chk({tag, " R6 done at finish"}, W'(done_o), 64'd1);
    chk({tag, " R1 atomic result"}, res_o, mont_ref(a, b, n, len));
    held = res_o;
    @(negedge clk_i);
    chk({tag, " R6 done one cycle"}, W'(done_o), 64'd0);
    chk({tag, " R6 result held"}, res_o, held);
  endtask

  task automatic run_partial(int len, bit first_is_step, string tag);
    logic [W-1:0] a, b, n;
    int c;
    make_ops(len, a, b, n);
    for (int k = 1; k <= len; k++) begin
      if (k == 1) req(!first_is_step, first_is_step, 1, len, a, b, n);
      else        req(0, 1, 0, len, 64'd0, 64'd0, 64'd0);
      wait_idle(c);
      chk({tag, " R3 step cycles"}, W'(c), (k == len) ? 64'd3 : 64'd2);
      chk({tag, " R3 done only on final"}, W'(done_o), W'(k == len));
    end
    chk({tag, " R1 partial result"}, res_o, mont_ref(a, b, n, len));
  endtask

  initial begin
    logic [W-1:0] a, b, n, a2, b2, n2;
    int c;
    repeat (3) @(negedge clk_i);
    chk("R9 reset busy", W'(busy_o), 64'd0);
    chk("R9 reset done", W'(done_o), 64'd0);
    chk("R9 reset res", res_o, 64'd0);
    rst_ni = 1'b1;

    run_atomic(1, "R10 len1");
    run_atomic(W, "R10 lenmax");
    for (int i = 0; i < 4; i++) begin
      run_atomic(2, "len2");
      run_atomic(7, "len7");
      run_atomic(33, "len33");
      run_atomic(W, "lenmax");
    end

    run_partial(1, 0, "R10 partial len1");
    run_partial(W, 0, "R10 partial lenmax");
    run_partial(5, 0, "partial len5");
    run_partial(19, 0, "partial len19");

    // R7: step with nothing loaded starts a partial operation
    run_partial(9, 1, "R7 step loads");

    // R4: inputs altered during run
    make_ops(24, a, b, n);
    req(1, 0, 0, 24, a, b, n);
    a_i = '1; b_i = '1; n_i = 64'h5; len_i = 3;
    wait_idle(c);
    chk("R4 inputs ignored during run", res_o, mont_ref(a, b, n, 24));

    // R5: start while busy ignored
    make_ops(30, a, b, n);
    make_ops(12, a2, b2, n2);
    req(1, 0, 0, 30, a, b, n);
    repeat (5) @(negedge clk_i);
    req(1, 0, 0, 12, a2, b2, n2);
    req(0, 1, 1, 12, a2, b2, n2);
    wait_idle(c);
    chk("R5 busy start ignored cycles", W'(c + 9), 64'd61);
    chk("R5 busy start ignored result", res_o, mont_ref(a, b, n, 30));

    // R8: start during paused partial discards its state
    make_ops(16, a, b, n);
    req(1, 0, 1, 16, a, b, n);
    wait_idle(c);
    req(0, 1, 0, 16, 64'd0, 64'd0, 64'd0);
    wait_idle(c);
    make_ops(10, a2, b2, n2);
    req(1, 0, 0, 10, a2, b2, n2);
    wait_idle(c);
    chk("R8 restart cycles", W'(c), 64'd21);
    chk("R8 restart result", res_o, mont_ref(a2, b2, n2, 10));
    // after discard, a step loads fresh operands (R7)
    run_partial(4, 1, "R8 after discard");

    repeat (3) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule